// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block handles in-band flow control for a UART. It looks at each received character and compares it with four programmable control characters: two "resume" codes (on1, on2) and two "pause" codes (off1, off2). A pause code that matches arms a transmit stop. A resume code that matches releases it. The transmitter sees the stop only at a character boundary. Control characters that match are taken out of the receive stream. All other characters go on, one cycle later, on a forwarding port.

On the transmit side the block watches a receive-FIFO threshold flag. It asks the transmitter to insert a pause code when the FIFO fills and a resume code when the FIFO drains. The code is sent as one byte or as an ordered pair of bytes, through a request/acknowledge handshake. A special-detect mode, allowed only when flow control is fully off, flags received characters equal to off2 and still passes them on as data. Serial framing, the FIFOs and the register file are outside this block.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset, `tx_halt_o`, `ins_req_o`, `fwd_valid_o` and `spec_hit_o` are all 0.
- R2: Receive mode is `mode_i[1:0]`. The value 2'b10 matches on1/off1 only and 2'b01 matches on2/off2 only. A matched character is not forwarded. Any other character appears on `fwd_data_o` with `fwd_valid_o` high in the cycle after its strobe.
- R3: With `mode_i[1:0]`=2'b11 and `mode_i[3:2]` not 2'b11, either on1 or on2 counts as resume, and either off1 or off2 counts as pause.
- R4: With `mode_i`=4'b1111, a pause needs off1 followed by off2 as two consecutive received characters. A resume needs on1 followed by on2. Neither character of a completed pair is forwarded.
- R5: In paired mode, a first character of a pair followed by any character other than its partner cancels the pair. The held first character is forwarded in the cycle after the second strobe, and the second character is forwarded in the next cycle.
- R6: A match sets (pause) or clears (resume) an internal stop state. `tx_halt_o` takes the value of that state only at a clock edge where `tx_bound_i` is high, using the state as it stood before that edge. At no other time does `tx_halt_o` change.
- R7: A character that matches both a pause and a resume pattern is treated as a pause.
- R8: With `mode_i[1:0]`=2'b00, no received character is compared: all are forwarded. The stop state is cleared, so the next boundary releases the halt.
- R9: When `spec_en_i` is 1 and `mode_i` is 4'b0000, a received character equal to off2 is forwarded with `spec_hit_o` high in the same cycle. When `mode_i` is nonzero, `spec_hit_o` stays 0.
- R10: Transmit mode is `mode_i[3:2]`. The value 2'b10 inserts on1/off1, 2'b01 inserts on2/off2, and 2'b11 inserts the pair on1 then on2, or off1 then off2. A request comes up in the cycle after `fifo_high_i` changes: a rise requests pause and a fall requests resume. `ins_char_o` stays stable until `ins_ack_i`, and each acknowledged byte advances the sequence.
- R11: With `mode_i[3:2]`=2'b00, no insertion is ever requested.
- R12: Each threshold transition gives one request sequence and no more. If the threshold changes back while a sequence is running, the opposite sequence starts in the cycle after the running one's final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | [3:2] transmit mode, [1:0] receive mode |
| spec_en_i | input | 1 | Special-character detect enable |
| on1_i | input | 8 | First resume code |
| on2_i | input | 8 | Second resume code |
| off1_i | input | 8 | First pause code |
| off2_i | input | 8 | Second pause code / special character |
| rx_valid_i | input | 1 | Received character strobe (strobes at least 2 cycles apart) |
| rx_data_i | input | 8 | Received character, bit 0 is the first-received LSB |
| fwd_valid_o | output | 1 | Forwarded data character valid |
| fwd_data_o | output | 8 | Forwarded data character |
| spec_hit_o | output | 1 | Forwarded character matched the special character |
| tx_bound_i | input | 1 | Transmitter at character boundary |
| tx_halt_o | output | 1 | Transmitter halt |
| fifo_high_i | input | 1 | Receive FIFO at or above its trigger level |
| ins_req_o | output | 1 | Insert-character request |
| ins_char_o | output | 8 | Character to insert |
| ins_ack_i | input | 1 | Insert request accepted |

## Verification
The bench targets a broken pair. A design that drops or reorders the held first character would lose data or swap two bytes. The bench also checks that a halt moves only on a boundary: a design that applies it at once would cut a character short in the middle of a frame. It also checks that a character matching both a pause and a resume code counts as a pause, and that special detect is silent once any flow-control bit is set. On the transmit side it checks that each code of a pair is held until acknowledged. It also flips the threshold in the middle of a sequence, where a design that lost the change would leave the far end paused for good.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_ON   = 2'd1,
    PEND_OFF  = 2'd2
  } pend_e;
endpackage

// File: rtl/sfc_rx_match.sv
module sfc_rx_match
  import sfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   mode_i,
  input  logic         spec_en_i,
  input  logic [W-1:0] on1_i,
  input  logic [W-1:0] on2_i,
  input  logic [W-1:0] off1_i,
  input  logic [W-1:0] off2_i,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  output logic         on_hit_o,
  output logic         off_hit_o,
  output logic         fwd_valid_o,
  output logic [W-1:0] fwd_data_o,
  output logic         spec_hit_o
);
  logic [1:0] rx_mode;
  logic       pair;
  logic       on_single, off_single;
  pend_e      pend_q, pend_d;
  logic [W-1:0] hold_q, hold_d, q_data_q, q_data_d;
  logic       q_valid_q, q_valid_d;
  logic       fwd_v_d, spec_d;
  logic [W-1:0] fwd_d;

  assign rx_mode = mode_i[1:0];
  assign pair    = (mode_i == 4'b1111);

  always_comb begin
    unique case (rx_mode)
      2'b10:   begin on_single = (rx_data_i == on1_i); off_single = (rx_data_i == off1_i); end
      2'b01:   begin on_single = (rx_data_i == on2_i); off_single = (rx_data_i == off2_i); end
      2'b11:   begin
        on_single  = (rx_data_i == on1_i)  || (rx_data_i == on2_i);
        off_single = (rx_data_i == off1_i) || (rx_data_i == off2_i);
      end
      default: begin on_single = 1'b0; off_single = 1'b0; end
    endcase
  end

  always_comb begin
    pend_d    = pair ? pend_q : PEND_NONE;
    hold_d    = hold_q;
    q_valid_d = 1'b0;
    q_data_d  = q_data_q;
    fwd_v_d   = q_valid_q;
    fwd_d     = q_data_q;
    spec_d    = 1'b0;
    on_hit_o  = 1'b0;
    off_hit_o = 1'b0;
    if (rx_valid_i) begin
      if (pair) begin
        unique case (pend_q)
          PEND_NONE: begin
            if (rx_data_i == off1_i) begin
              pend_d = PEND_OFF; hold_d = rx_data_i;
            end else if (rx_data_i == on1_i) begin
              pend_d = PEND_ON; hold_d = rx_data_i;
            end else begin
              fwd_v_d = 1'b1; fwd_d = rx_data_i;
            end
          end
          PEND_ON, PEND_OFF: begin
            pend_d = PEND_NONE;
            if ((pend_q == PEND_ON) && (rx_data_i == on2_i)) begin
              on_hit_o = 1'b1;
            end else if ((pend_q == PEND_OFF) && (rx_data_i == off2_i)) begin
              off_hit_o = 1'b1;
            end else begin
              // broken pair: release held byte now, current byte next cycle
              fwd_v_d   = 1'b1;
              fwd_d     = hold_q;
              q_valid_d = 1'b1;
              q_data_d  = rx_data_i;
            end
          end
          default: pend_d = PEND_NONE;
        endcase
      end else if (off_single) begin
        off_hit_o = 1'b1;
      end else if (on_single) begin
        on_hit_o = 1'b1;
      end else begin
        fwd_v_d = 1'b1;
        fwd_d   = rx_data_i;
        spec_d  = spec_en_i && (mode_i == 4'b0000) && (rx_data_i == off2_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= PEND_NONE;
      hold_q      <= '0;
      q_valid_q   <= 1'b0;
      q_data_q    <= '0;
      fwd_valid_o <= 1'b0;
      fwd_data_o  <= '0;
      spec_hit_o  <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      hold_q      <= hold_d;
      q_valid_q   <= q_valid_d;
      q_data_q    <= q_data_d;
      fwd_valid_o <= fwd_v_d;
      fwd_data_o  <= fwd_d;
      spec_hit_o  <= spec_d;
    end
  end
endmodule

// File: rtl/sfc_halt.sv
module sfc_halt (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rx_mode_i,
  input  logic       on_hit_i,
  input  logic       off_hit_i,
  input  logic       tx_bound_i,
  output logic       tx_halt_o
);
  logic stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q    <= 1'b0;
      tx_halt_o <= 1'b0;
    end else begin
      if (rx_mode_i == 2'b00) stop_q <= 1'b0;
      else if (off_hit_i)     stop_q <= 1'b1;
      else if (on_hit_i)      stop_q <= 1'b0;
      if (tx_bound_i) tx_halt_o <= stop_q;
    end
  end
endmodule

// File: rtl/sfc_tx_insert.sv
module sfc_tx_insert #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   tx_mode_i,
  input  logic [W-1:0] on1_i,
  input  logic [W-1:0] on2_i,
  input  logic [W-1:0] off1_i,
  input  logic [W-1:0] off2_i,
  input  logic         fifo_high_i,
  input  logic         ins_ack_i,
  output logic         ins_req_o,
  output logic [W-1:0] ins_char_o
);
  logic busy_q, sent_q, kind_q, second_q;

  function automatic logic [W-1:0] pick(input logic pause, input logic use2,
                                        input logic [W-1:0] a1, input logic [W-1:0] a2,
                                        input logic [W-1:0] f1, input logic [W-1:0] f2);
    if (pause) pick = use2 ? f2 : f1;
    else       pick = use2 ? a2 : a1;
  endfunction

  assign ins_req_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      sent_q     <= 1'b0;
      kind_q     <= 1'b0;
      second_q   <= 1'b0;
      ins_char_o <= '0;
    end else if (!busy_q) begin
      if (tx_mode_i == 2'b00) begin
        sent_q <= 1'b0;
      end else if (fifo_high_i != sent_q) begin
        busy_q     <= 1'b1;
        kind_q     <= fifo_high_i;
        second_q   <= (tx_mode_i == 2'b11);
        ins_char_o <= pick(fifo_high_i, tx_mode_i == 2'b01, on1_i, on2_i, off1_i, off2_i);
      end
    end else if (ins_ack_i) begin
      if (second_q) begin
        second_q   <= 1'b0;
        ins_char_o <= pick(kind_q, 1'b1, on1_i, on2_i, off1_i, off2_i);
      end else begin
        busy_q <= 1'b0;
        sent_q <= kind_q;
      end
    end
  end
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   mode_i,
  input  logic         spec_en_i,
  input  logic [W-1:0] on1_i,
  input  logic [W-1:0] on2_i,
  input  logic [W-1:0] off1_i,
  input  logic [W-1:0] off2_i,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_data_i,
  output logic         fwd_valid_o,
  output logic [W-1:0] fwd_data_o,
  output logic         spec_hit_o,
  input  logic         tx_bound_i,
  output logic         tx_halt_o,
  input  logic         fifo_high_i,
  output logic         ins_req_o,
  output logic [W-1:0] ins_char_o,
  input  logic         ins_ack_i
);
  logic on_hit, off_hit;

  sfc_rx_match #(.W(W)) u_rx (
    .clk_i, .rst_ni, .mode_i, .spec_en_i,
    .on1_i, .on2_i, .off1_i, .off2_i,
    .rx_valid_i, .rx_data_i,
    .on_hit_o(on_hit), .off_hit_o(off_hit),
    .fwd_valid_o, .fwd_data_o, .spec_hit_o
  );

  sfc_halt u_halt (
    .clk_i, .rst_ni, .rx_mode_i(mode_i[1:0]),
    .on_hit_i(on_hit), .off_hit_i(off_hit),
    .tx_bound_i, .tx_halt_o
  );

  sfc_tx_insert #(.W(W)) u_tx (
    .clk_i, .rst_ni, .tx_mode_i(mode_i[3:2]),
    .on1_i, .on2_i, .off1_i, .off2_i,
    .fifo_high_i, .ins_ack_i, .ins_req_o, .ins_char_o
  );
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   mode_i,
  input logic         fwd_valid_o,
  input logic         spec_hit_o,
  input logic         tx_bound_i,
  input logic         tx_halt_o,
  input logic         ins_req_o,
  input logic [W-1:0] ins_char_o,
  input logic         ins_ack_i
);
  // R9
  spec_with_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_hit_o |-> fwd_valid_o);

  // R6
  halt_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_halt_o) |-> $past(tx_bound_i));

  // R10
  ins_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_req_o && !ins_ack_i) |=> (ins_req_o && $stable(ins_char_o)));

  // R11
  tx_none_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ins_req_o && mode_i[3:2] == 2'b00) |=> !ins_req_o);
endmodule

bind xonxoff_flow_ctrl sfc_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
  .fwd_valid_o(fwd_valid_o), .spec_hit_o(spec_hit_o),
  .tx_bound_i(tx_bound_i), .tx_halt_o(tx_halt_o),
  .ins_req_o(ins_req_o), .ins_char_o(ins_char_o), .ins_ack_i(ins_ack_i)
);

// File: tb/xonxoff_flow_ctrl_tb.sv
module xonxoff_flow_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h12, OFF1 = 8'h13, OFF2 = 8'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mode = 4'b0;
  logic spec_en = 1'b0;
  logic [7:0] on1 = ON1, on2 = ON2, off1 = OFF1, off2 = OFF2;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic fwd_valid, spec_hit, tx_halt, ins_req;
  logic [7:0] fwd_data, ins_char;
  logic tx_bound = 1'b0, fifo_high = 1'b0, ins_ack = 1'b0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xonxoff_flow_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .spec_en_i(spec_en),
    .on1_i(on1), .on2_i(on2), .off1_i(off1), .off2_i(off2),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .fwd_valid_o(fwd_valid), .fwd_data_o(fwd_data), .spec_hit_o(spec_hit),
    .tx_bound_i(tx_bound), .tx_halt_o(tx_halt),
    .fifo_high_i(fifo_high), .ins_req_o(ins_req), .ins_char_o(ins_char),
    .ins_ack_i(ins_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic boundary();
    @(negedge clk); tx_bound = 1'b1;
    @(negedge clk); tx_bound = 1'b0;
  endtask

  task automatic ack_one();
    ins_ack = 1'b1;
    @(negedge clk); ins_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 halt", tx_halt, 0);
    check("R1 req", ins_req, 0);
    check("R1 fwd", fwd_valid, 0);
    check("R1 spec", spec_hit, 0);
  endtask

  task automatic t_rx_single();
    mode = 4'b0010;
    send(ON1);  check("R2 on1 consumed", fwd_valid, 0);
    idle(1);
    send(8'h41); check("R2 data valid", fwd_valid, 1); check("R2 data", fwd_data, 8'h41);
    idle(1);
    mode = 4'b0001;
    send(ON2);  check("R2 on2 consumed", fwd_valid, 0);
    idle(1);
    send(ON1);  check("R2 on1 is data in mode 01", fwd_valid, 1); check("R2 on1 value", fwd_data, ON1);
    idle(1);
  endtask

  task automatic t_rx_either();
    mode = 4'b1011;
    send(OFF2); check("R3 off2 consumed", fwd_valid, 0);
    boundary(); check("R3 halt by off2", tx_halt, 1);
    send(ON1);  check("R3 on1 consumed", fwd_valid, 0);
    boundary(); check("R3 release by on1", tx_halt, 0);
  endtask

  task automatic t_pair();
    mode = 4'b1111;
    send(OFF1); check("R4 off1 held", fwd_valid, 0);
    idle(1);
    send(OFF2); check("R4 off2 consumed", fwd_valid, 0);
    idle(1);    check("R4 nothing queued", fwd_valid, 0);
    boundary(); check("R4 halt by pair", tx_halt, 1);
    send(ON1); idle(1); send(ON2);
    boundary(); check("R4 release by pair", tx_halt, 0);
  endtask

  task automatic t_pair_break();
    mode = 4'b1111;
    send(ON1);   check("R5 first held", fwd_valid, 0);
    idle(1);
    send(8'h55); check("R5 held out valid", fwd_valid, 1); check("R5 held out data", fwd_data, ON1);
    @(negedge clk); check("R5 second valid", fwd_valid, 1); check("R5 second data", fwd_data, 8'h55);
    idle(1);    check("R5 done", fwd_valid, 0);
    boundary(); check("R5 no halt change", tx_halt, 0);
  endtask

  task automatic t_halt();
    mode = 4'b0010;
    send(OFF1); check("R6 no boundary yet", tx_halt, 0);
    idle(3);    check("R6 still waiting", tx_halt, 0);
    boundary(); check("R6 halt at boundary", tx_halt, 1);
    send(ON1);  check("R6 held until boundary", tx_halt, 1);
    boundary(); check("R6 released", tx_halt, 0);
  endtask

  task automatic t_prio();
    mode = 4'b0010; on1 = OFF1;
    send(OFF1); check("R7 consumed", fwd_valid, 0);
    boundary(); check("R7 pause wins", tx_halt, 1);
    on1 = ON1;
    send(ON1); boundary(); check("R7 restore", tx_halt, 0);
  endtask

  task automatic t_none();
    mode = 4'b0010;
    send(OFF1);
    mode = 4'b0000;
    send(OFF1); check("R8 off1 forwarded", fwd_valid, 1); check("R8 off1 data", fwd_data, OFF1);
    boundary(); check("R8 stop cleared", tx_halt, 0);
  endtask

  task automatic t_spec();
    mode = 4'b0000; spec_en = 1'b1;
    send(OFF2);  check("R9 fwd", fwd_valid, 1); check("R9 flag", spec_hit, 1); check("R9 data", fwd_data, OFF2);
    idle(1);
    send(8'h20); check("R9 no flag", spec_hit, 0); check("R9 other fwd", fwd_valid, 1);
    idle(1);
    mode = 4'b0010;
    send(OFF2);  check("R9 ignored fwd", fwd_valid, 1); check("R9 ignored flag", spec_hit, 0);
    spec_en = 1'b0; mode = 4'b0000;
    idle(1);
  endtask

  task automatic t_tx_pair();
    mode = 4'b1100;
    @(negedge clk); fifo_high = 1'b1;
    @(negedge clk); check("R10 req", ins_req, 1); check("R10 off1", ins_char, OFF1);
    @(negedge clk); check("R10 stable", ins_char, OFF1);
    ack_one();      check("R10 req2", ins_req, 1); check("R10 off2", ins_char, OFF2);
    ack_one();      check("R10 done", ins_req, 0);
    idle(3);        check("R12 single sequence", ins_req, 0);
    fifo_high = 1'b0;
    @(negedge clk); check("R10 on1", ins_char, ON1); check("R10 on req", ins_req, 1);
    ack_one();      check("R10 on2", ins_char, ON2);
    ack_one();      check("R10 on done", ins_req, 0);
  endtask

  task automatic t_tx_single();
    mode = 4'b0100;
    fifo_high = 1'b1;
    @(negedge clk); check("R10 single off2", ins_char, OFF2); check("R10 single req", ins_req, 1);
    ack_one();      check("R10 single done", ins_req, 0);
    fifo_high = 1'b0;
    @(negedge clk); check("R10 single on2", ins_char, ON2);
    ack_one();      check("R10 single on done", ins_req, 0);
  endtask

  task automatic t_tx_off();
    mode = 4'b0000;
    fifo_high = 1'b1;
    idle(3); check("R11 no request", ins_req, 0);
    fifo_high = 1'b0;
    idle(2); check("R11 still none", ins_req, 0);
  endtask

  task automatic t_tx_change();
    mode = 4'b1000;
    fifo_high = 1'b1;
    @(negedge clk); check("R12 off1", ins_char, OFF1);
    fifo_high = 1'b0;
    idle(1);        check("R12 running", ins_char, OFF1);
    ack_one();      check("R12 gap", ins_req, 0);
    @(negedge clk); check("R12 follow req", ins_req, 1); check("R12 follow on1", ins_char, ON1);
    ack_one();      check("R12 follow done", ins_req, 0);
    idle(3);        check("R12 settled", ins_req, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_rx_single();
    t_rx_either();
    t_pair();
    t_pair_break();
    t_halt();
    t_prio();
    t_none();
    t_spec();
    t_tx_pair();
    t_tx_single();
    t_tx_off();
    t_tx_change();
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule